// File: doc/BRIEF.md
# Far-End Alarm Codeword Transmitter

This block sends six-bit far-end alarm and control messages over the single-bit overhead channel of a DS3 framer. It sends one channel bit for each bit-slot strobe from the framer. The framer raises that strobe once per M-frame, in the last C-bit position of the first subframe. A processor write port supplies the message and an enable flag. The block adds the framing on its own: a 16-bit codeword of eight ones, a zero, the six message bits and a closing zero.

Each enabled write makes the block send that codeword ten times back to back. It then raises an interrupt to ask for the next message. While it waits, it sends the all-ones idle flag. A write with the enable flag clear puts the block in continuous idle with no interrupts. The output reaches the channel only when the framer mode selects the internal DS3 framer and the alarm control is not inserting AIS.

Top module: `alarm_code_tx`

## Requirements
- R1: The codeword is sent least significant position first. Slots 0 to 7 carry 1, slot 8 carries 0, slots 9 to 14 carry message bits 0 to 5 in that order, and slot 15 carries 0.
- R2: An enabled write (wr_enable = 1) produces exactly ten back-to-back codewords of that message. A codeword begins on the strobe that follows the strobe during which the write was taken up. While idle, a write is taken up on the next strobe.
- R3: tx_irq rises right after the 160th codeword slot of an uninterrupted burst (10 × 16 strobes) and at no other time.
- R4: tx_irq is 0 in the cycle after any write, whatever the value of wr_enable. Otherwise it stays asserted. It is not cleared by idle time or by further strobes.
- R5: A write with wr_enable = 0 stops transmission at the next codeword boundary. The channel then carries 1 on every slot and tx_irq stays 0 until the next enabled write.
- R6: The channel bit changes only on a clock edge where slot_stb is 1. Cycles without a strobe leave it unchanged.
- R7: framer_mode 2'b00 selects the internal DS3 framer. For any other value, tx_oe is 0 and tx_bit is 0, while the sequence keeps advancing on strobes.
- R8: alarm_sel 2'b01 (AIS) forces tx_oe and tx_bit to 0. The values 2'b00 (none), 2'b10 (yellow) and 2'b11 (idle code) leave the channel unaffected.
- R9: A write made during a codeword is held until that codeword's last slot. The new message then starts at the next slot with a fresh count of ten, so no codeword is cut short.
- R10: When no codeword is active, the channel bit is 1. After reset, tx_bit is 1 and tx_irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | One-cycle write strobe for the message register |
| wr_msg | input | 6 | Six-bit alarm/control message |
| wr_enable | input | 1 | 1 = transmit the message, 0 = go idle |
| slot_stb | input | 1 | Framer bit-slot strobe, one per M-frame |
| framer_mode | input | 2 | Framer type; 2'b00 = internal DS3 |
| alarm_sel | input | 2 | Alarm insertion: 00 none, 01 AIS, 10 yellow, 11 idle code |
| tx_bit | output | 1 | Channel bit for the current slot |
| tx_oe | output | 1 | Channel bit is driven onto the overhead slot |
| tx_irq | output | 1 | Refill interrupt, also the readable status bit |

## Verification
The bench tries several bursts against a queue of expected channel bits:
- A lone enabled message followed by idle time checks the bit order and the 160-strobe interrupt spacing, and shows that the interrupt stays set while idle.
- A second message written partway through a codeword shows the difference between switching at the boundary and truncating. A truncation would shift every later bit.
- A disabling write during a codeword separates "idle with no interrupt" from "burst completed".
- A burst sent while the framer mode and alarm select change shows that only AIS and non-DS3 modes suppress the output, and that counting continues underneath.

// File: rtl/alarm_tx_pkg.sv
package alarm_tx_pkg;
  localparam int MSG_W  = 6;
  localparam int FLAG_W = 8;
  localparam int CW_W   = FLAG_W + MSG_W + 2;

  localparam logic [1:0] FM_DS3_INT = 2'b00;
  localparam logic [1:0] ALM_AIS    = 2'b01;

  // Codeword: position 0 is sent first.
  function automatic logic [CW_W-1:0] build_cw(input logic [MSG_W-1:0] msg);
    return {1'b0, msg, 1'b0, {FLAG_W{1'b1}}};
  endfunction

  function automatic logic chan_enabled(input logic [1:0] mode, input logic [1:0] alm);
    return (mode == FM_DS3_INT) && (alm != ALM_AIS);
  endfunction
endpackage

// File: rtl/alm_pend_reg.sv
module alm_pend_reg
  import alarm_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [MSG_W-1:0] wr_msg,
  input  logic             wr_enable,
  input  logic             consume,
  output logic             pend_valid,
  output logic [MSG_W-1:0] pend_msg,
  output logic             pend_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_msg   <= '0;
      pend_en    <= 1'b0;
    end else if (wr_en) begin
      pend_valid <= 1'b1;
      pend_msg   <= wr_msg;
      pend_en    <= wr_enable;
    end else if (consume) begin
      pend_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/alm_seq.sv
module alm_seq
  import alarm_tx_pkg::*;
#(
  parameter int REPEATS = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_stb,
  input  logic             pend_valid,
  input  logic [MSG_W-1:0] pend_msg,
  input  logic             pend_en,
  output logic             consume,
  output logic             raw_bit,
  output logic             active,
  output logic             cw_end,
  output logic             burst_done
);
  localparam int IDX_W = $clog2(CW_W);
  localparam int REP_W = (REPEATS > 1) ? $clog2(REPEATS) : 1;

  logic [IDX_W-1:0] bit_idx;
  logic [REP_W-1:0] rep_cnt;
  logic [MSG_W-1:0] cur_msg;
  logic [CW_W-1:0]  cw;
  logic             idle_take, last_rep, load;

  assign cw         = build_cw(cur_msg);
  assign cw_end     = slot_stb && active && (bit_idx == IDX_W'(CW_W - 1));
  assign idle_take  = slot_stb && !active && pend_valid;
  assign consume    = idle_take || (cw_end && pend_valid);
  assign last_rep   = (rep_cnt == REP_W'(REPEATS - 1));
  assign burst_done = cw_end && !pend_valid && last_rep;
  assign load       = consume && pend_en;
  assign raw_bit    = active ? cw[bit_idx] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      bit_idx <= '0;
      rep_cnt <= '0;
      cur_msg <= '0;
    end else if (load) begin
      active  <= 1'b1;
      bit_idx <= '0;
      rep_cnt <= '0;
      cur_msg <= pend_msg;
    end else if (cw_end) begin
      bit_idx <= '0;
      if (pend_valid || last_rep) active <= 1'b0;
      else                        rep_cnt <= rep_cnt + 1'b1;
    end else if (slot_stb && active) begin
      bit_idx <= bit_idx + 1'b1;
    end
  end
endmodule

// File: rtl/alarm_code_tx.sv
module alarm_code_tx
  import alarm_tx_pkg::*;
#(
  parameter int REPEATS = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [5:0] wr_msg,
  input  logic       wr_enable,
  input  logic       slot_stb,
  input  logic [1:0] framer_mode,
  input  logic [1:0] alarm_sel,
  output logic       tx_bit,
  output logic       tx_oe,
  output logic       tx_irq
);
  logic             pend_valid, pend_en, consume;
  logic [MSG_W-1:0] pend_msg;
  logic             raw_bit, active, cw_end, burst_done;

  alm_pend_reg u_pend (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_msg(wr_msg),
    .wr_enable(wr_enable), .consume(consume), .pend_valid(pend_valid),
    .pend_msg(pend_msg), .pend_en(pend_en)
  );

  alm_seq #(.REPEATS(REPEATS)) u_seq (
    .clk(clk), .rst_n(rst_n), .slot_stb(slot_stb), .pend_valid(pend_valid),
    .pend_msg(pend_msg), .pend_en(pend_en), .consume(consume),
    .raw_bit(raw_bit), .active(active), .cw_end(cw_end), .burst_done(burst_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          tx_irq <= 1'b0;
    else if (wr_en)      tx_irq <= 1'b0;
    else if (burst_done) tx_irq <= 1'b1;
  end

  assign tx_oe  = chan_enabled(framer_mode, alarm_sel);
  assign tx_bit = tx_oe & raw_bit;
endmodule

// File: rtl/alm_tx_chk.sv
module alm_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic slot_stb,
  input logic tx_irq,
  input logic tx_bit,
  input logic tx_oe,
  input logic raw_bit,
  input logic active,
  input logic burst_done
);
  AST_IRQ_CLEARED_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !tx_irq); // R4
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_irq && !wr_en) |=> tx_irq); // R4
  AST_IRQ_ONLY_AFTER_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_irq) |-> $past(burst_done)); // R3
  AST_BIT_HOLDS_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_stb |=> $stable(raw_bit)); // R6
  AST_IDLE_SENDS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> raw_bit); // R10
  AST_UNDRIVEN_IS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_oe |-> !tx_bit); // R7
endmodule

bind alarm_code_tx alm_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .slot_stb(slot_stb),
  .tx_irq(tx_irq), .tx_bit(tx_bit), .tx_oe(tx_oe), .raw_bit(raw_bit),
  .active(active), .burst_done(burst_done)
);

// File: tb/sim_alarm_code_tx.sv
`timescale 1ns/1ps
module sim_alarm_code_tx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_enable = 1'b0, slot_stb = 1'b0;
  logic [5:0] wr_msg = '0;
  logic [1:0] framer_mode = 2'b00, alarm_sel = 2'b00;
  logic tx_bit, tx_oe, tx_irq;

  int n_chk = 0, n_fail = 0;
  logic  exp_q[$];
  string req_q[$];

  always #2.5 clk = ~clk;

  alarm_code_tx u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_msg(wr_msg),
    .wr_enable(wr_enable), .slot_stb(slot_stb), .framer_mode(framer_mode),
    .alarm_sel(alarm_sel), .tx_bit(tx_bit), .tx_oe(tx_oe), .tx_irq(tx_irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected codeword position i for message m: ones, zero, message LSB first, zero
  function automatic logic ref_bit(logic [5:0] m, int i);
    if (i < 8) return 1'b1;
    if (i == 8 || i == 15) return 1'b0;
    return m[i-9];
  endfunction

  function automatic logic passes();
    return (framer_mode == 2'b00) && (alarm_sel != 2'b01);
  endfunction

  // Driver: push expected port value, then issue one strobe
  task automatic slot(logic raw, string req);
    exp_q.push_back(passes() ? raw : 1'b0);
    req_q.push_back(req);
    @(posedge clk); #1 slot_stb = 1'b1;
    @(posedge clk); #1 slot_stb = 1'b0;
  endtask

  task automatic write(logic [5:0] m, logic en);
    @(posedge clk); #1 wr_en = 1'b1; wr_msg = m; wr_enable = en;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic send_bits(logic [5:0] m, int from, int to, string req);
    for (int i = from; i < to; i++) slot(ref_bit(m, i % 16), req);
  endtask

  // Monitor: compare the channel bit in the strobe cycle
  always @(negedge clk) begin
    if (rst_n && slot_stb) begin
      if (exp_q.size() == 0) check("R1 queue-underflow", 32'd1, 32'd0);
      else begin
        automatic logic e = exp_q.pop_front();
        automatic string r = req_q.pop_front();
        check(r, {31'd0, tx_bit}, {31'd0, e});
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset bit", {31'd0, tx_bit}, 32'd1);
    check("R10 reset irq", {31'd0, tx_irq}, 32'd0);

    // Single burst: format, ten repeats, interrupt spacing
    write(6'b101101, 1'b1);
    slot(1'b1, "R10 idle before start");
    send_bits(6'b101101, 0, 159, "R1 R2 burst A");
    check("R3 irq before 160th slot", {31'd0, tx_irq}, 32'd0);
    send_bits(6'b101101, 159, 160, "R2 last slot");
    check("R3 irq after 160th slot", {31'd0, tx_irq}, 32'd1);
    for (int i = 0; i < 20; i++) slot(1'b1, "R10 idle after burst");
    check("R4 irq held while idle", {31'd0, tx_irq}, 32'd1);

    // Mid-codeword rewrite takes effect at the boundary
    write(6'b010011, 1'b1);
    check("R4 irq cleared by write", {31'd0, tx_irq}, 32'd0);
    slot(1'b1, "R10 idle before start");
    send_bits(6'b010011, 0, 20, "R1 burst B");
    write(6'b110001, 1'b1);
    send_bits(6'b010011, 20, 32, "R9 B not truncated");
    send_bits(6'b110001, 0, 159, "R9 burst C");
    check("R3 no irq from replaced burst", {31'd0, tx_irq}, 32'd0);
    send_bits(6'b110001, 159, 160, "R9 C last");
    check("R3 irq after C", {31'd0, tx_irq}, 32'd1);

    // Disable mid-codeword, plus strobe-less hold
    write(6'b111000, 1'b1);
    slot(1'b1, "R10 idle before start");
    send_bits(6'b111000, 0, 3, "R1 burst D");
    repeat (30) @(posedge clk);
    #1 check("R6 hold without strobe", {31'd0, tx_bit}, {31'd0, ref_bit(6'b111000, 3)});
    send_bits(6'b111000, 3, 5, "R6 resume D");
    write(6'b000111, 1'b0);
    send_bits(6'b111000, 5, 16, "R5 finish codeword");
    for (int i = 0; i < 200; i++) slot(1'b1, "R5 disabled idle");
    check("R5 no irq when disabled", {31'd0, tx_irq}, 32'd0);

    // Mode and alarm gating during a burst
    write(6'b100110, 1'b1);
    slot(1'b1, "R10 idle before start");
    send_bits(6'b100110, 0, 16, "R1 burst E");
    #1 framer_mode = 2'b10;
    #1 check("R7 oe off in other mode", {31'd0, tx_oe}, 32'd0);
    send_bits(6'b100110, 16, 48, "R7 gated");
    framer_mode = 2'b00; alarm_sel = 2'b10;
    #1 check("R8 yellow keeps oe", {31'd0, tx_oe}, 32'd1);
    send_bits(6'b100110, 48, 64, "R8 yellow");
    alarm_sel = 2'b11;
    send_bits(6'b100110, 64, 80, "R8 idle code");
    alarm_sel = 2'b01;
    #1 check("R8 AIS drops oe", {31'd0, tx_oe}, 32'd0);
    send_bits(6'b100110, 80, 112, "R8 AIS suppressed");
    alarm_sel = 2'b00;
    send_bits(6'b100110, 112, 160, "R2 burst E tail");
    check("R3 irq after gated burst", {31'd0, tx_irq}, 32'd1);
    slot(1'b1, "R10 idle end");

    repeat (4) @(posedge clk);
    check("R1 queue drained", exp_q.size(), 32'd0);
    finish_run();
  end
endmodule